// File: doc/BRIEF.md
# Command-Mode Sector Register Front End

This block is the host-side register window of a sector storage controller attached to an 8-bit CPU bus. The host opens the window by writing a key value into a write-only control latch. While the window is open, it can load a 24-bit sector number into three parameter registers, issue a command, poll a status byte, and move a whole sector through a pair of data-port registers. When the window is closed, every read returns 0xFF and only the latch accepts writes.

Commands come in two kinds, chosen by bit 5 of the command byte. When bit 5 is set, the host first pushes a block into an internal buffer and the controller executes afterwards. When bit 5 is clear, the controller executes first; a sector read then leaves a block for the host to pull. Execution is handed to the storage side through a request/acknowledge port. The storage side reads or fills the same buffer by byte address.

Top module: `sector_cmd_regif`

## Requirements
- R1: The window is open only while the control latch (offset 0) holds 0x43. While it is closed, every read returns 0xFF and writes to offsets 8 to 11 are ignored.
- R2: Writing any other value to offset 0 closes the window and aborts the command in progress: busy and ready clear at once and `be_req` drops in the next cycle.
- R3: A status read at offset 8 returns bit 0 busy, bit 1 ready, bit 7 failed and zeros elsewhere. It has no side effect on a transfer in progress, and ready is never set without busy.
- R4: Offsets 9, 10 and 11 are read/write parameter registers while idle. A command write presents the sector number {off9, off10, off11} (high byte first) on `be_lba`.
- R5: Command 0x80 raises `be_req` with `be_write` = 0, and the storage side fills the buffer through `be_we`. After `be_ack`, ready is set and the host reads 128 pairs: offset 10 gives byte 2k and offset 11 gives byte 2k+1 and steps to the next pair. After the last byte, busy and ready clear.
- R6: Commands 0xA0 and 0xE0 (bit 5 set) set busy and ready at once, and the host writes 256 bytes in the same A/B pair order. After the last byte, ready drops, `be_req` rises with `be_write` = 1, the storage side reads the buffer through `be_addr`/`be_rdata`, and busy stays set until `be_ack`.
- R7: Command 0xC0 raises `be_req`. On `be_ack`, busy clears and ready is never set.
- R8: A command byte other than 0x80, 0xA0, 0xC0 or 0xE0 sets failed, leaves busy clear and raises no request. A valid command clears failed.
- R9: `be_ack` together with `be_fail` ends the command with failed set, busy clear and ready clear.
- R10: Reads of the control latch and of offsets 1 to 7 and 12 to 15 return 0xFF.
- R11: A command write while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 4 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data for the current offset |
| be_req | output | 1 | Execute request to the storage side |
| be_write | output | 1 | Request carries a host-supplied block |
| be_cmd | output | 8 | Command byte |
| be_lba | output | 24 | Sector number |
| be_addr | input | 8 | Buffer byte address from the storage side |
| be_rdata | output | 8 | Buffer byte at `be_addr` |
| be_we | input | 1 | Storage-side buffer write enable |
| be_wdata | input | 8 | Storage-side buffer write data |
| be_ack | input | 1 | Request complete |
| be_fail | input | 1 | Completion is a failure, valid with `be_ack` |

## Verification
The bench builds the block with its defaults: a 256-byte block and key 0x43. With these values the pair counter runs through its full range and wraps at the last pair. This lets the bench check the exact 128-pair boundary in both directions, against a stub sector memory with a fill pattern that depends on the address. The storage stub's response delay is adjustable. This keeps a request open long enough to close the window in the middle of execution and to inject a failing acknowledge.

// File: rtl/sector_cmd_regif.sv
module sector_cmd_regif #(
  parameter int          BLOCK_BYTES = 256,
  parameter logic [7:0]  MODE_KEY    = 8'h43
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [3:0]                       cpu_addr,
  input  logic [7:0]                       cpu_wdata,
  input  logic                             cpu_wr,
  input  logic                             cpu_rd,
  output logic [7:0]                       cpu_rdata,
  output logic                             be_req,
  output logic                             be_write,
  output logic [7:0]                       be_cmd,
  output logic [23:0]                      be_lba,
  input  logic [$clog2(BLOCK_BYTES)-1:0]   be_addr,
  output logic [7:0]                       be_rdata,
  input  logic                             be_we,
  input  logic [7:0]                       be_wdata,
  input  logic                             be_ack,
  input  logic                             be_fail
);
  localparam int IDX_W  = $clog2(BLOCK_BYTES);
  localparam int PAIR_W = IDX_W - 1;
  localparam logic [3:0] OFF_LATCH = 4'd0;
  localparam logic [3:0] OFF_CMD   = 4'd8;
  localparam logic [3:0] OFF_P1    = 4'd9;
  localparam logic [3:0] OFF_P2    = 4'd10;
  localparam logic [3:0] OFF_P3    = 4'd11;

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_EXEC, S_PULL} st_t;

  st_t               st;
  logic [7:0]        latch, p1, p2, p3, cmd;
  logic [23:0]       lba;
  logic              failed;
  logic [PAIR_W-1:0] pair;
  logic [7:0]        buffer [BLOCK_BYTES];

  logic in_mode, busy, ready;
  assign in_mode = (latch == MODE_KEY);
  assign busy    = (st != S_IDLE);
  assign ready   = (st == S_PUSH) || (st == S_PULL);

  logic sel_latch, sel_cmd, sel_p1, sel_a, sel_b;
  assign sel_latch = (cpu_addr == OFF_LATCH);
  assign sel_cmd   = (cpu_addr == OFF_CMD);
  assign sel_p1    = (cpu_addr == OFF_P1);
  assign sel_a     = (cpu_addr == OFF_P2);
  assign sel_b     = (cpu_addr == OFF_P3);

  logic cmd_known, leave, xfer_wr, xfer_rd, last_pair;
  assign cmd_known = (cpu_wdata == 8'h80) || (cpu_wdata == 8'hA0) ||
                     (cpu_wdata == 8'hC0) || (cpu_wdata == 8'hE0);
  assign leave     = cpu_wr && sel_latch && (cpu_wdata != MODE_KEY);
  assign xfer_wr   = cpu_wr && in_mode && (st == S_PUSH) && (sel_a || sel_b);
  assign xfer_rd   = cpu_rd && in_mode && (st == S_PULL) && (sel_a || sel_b);
  assign last_pair = &pair;

  logic [IDX_W-1:0] idx_a, idx_b;
  assign idx_a = {pair, 1'b0};
  assign idx_b = {pair, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      latch  <= 8'h00;
      p1     <= 8'h00;
      p2     <= 8'h00;
      p3     <= 8'h00;
      cmd    <= 8'h00;
      lba    <= 24'h0;
      failed <= 1'b0;
      pair   <= '0;
    end else begin
      if (cpu_wr && sel_latch) latch <= cpu_wdata;
      if (leave) begin
        st   <= S_IDLE;
        pair <= '0;
      end else if (in_mode) begin
        case (st)
          S_IDLE: begin
            if (cpu_wr && sel_p1) p1 <= cpu_wdata;
            if (cpu_wr && sel_a)  p2 <= cpu_wdata;
            if (cpu_wr && sel_b)  p3 <= cpu_wdata;
            if (cpu_wr && sel_cmd) begin
              if (cmd_known) begin
                cmd    <= cpu_wdata;
                lba    <= {p1, p2, p3};
                failed <= 1'b0;
                pair   <= '0;
                st     <= cpu_wdata[5] ? S_PUSH : S_EXEC;
              end else begin
                failed <= 1'b1;
              end
            end
          end
          S_PUSH: if (xfer_wr && sel_b) begin
            pair <= pair + 1'b1;
            if (last_pair) st <= S_EXEC;
          end
          S_EXEC: if (be_ack) begin
            pair <= '0;
            if (be_fail) begin
              failed <= 1'b1;
              st     <= S_IDLE;
            end else if (cmd == 8'h80) begin
              st <= S_PULL;
            end else begin
              st <= S_IDLE;
            end
          end
          S_PULL: if (xfer_rd && sel_b) begin
            pair <= pair + 1'b1;
            if (last_pair) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (xfer_wr)
      buffer[sel_a ? idx_a : idx_b] <= cpu_wdata;
    else if ((st == S_EXEC) && be_we && !cmd[5])
      buffer[be_addr] <= be_wdata;
  end

  always_comb begin
    cpu_rdata = 8'hFF;
    if (in_mode) begin
      case (cpu_addr)
        OFF_CMD: cpu_rdata = {failed, 5'b0, ready, busy};
        OFF_P1:  cpu_rdata = p1;
        OFF_P2:  cpu_rdata = ready ? buffer[idx_a] : p2;
        OFF_P3:  cpu_rdata = ready ? buffer[idx_b] : p3;
        default: cpu_rdata = 8'hFF;
      endcase
    end
  end

  assign be_req   = (st == S_EXEC);
  assign be_write = cmd[5];
  assign be_cmd   = cmd;
  assign be_lba   = lba;
  assign be_rdata = buffer[be_addr];
endmodule

module sector_cmd_regif_chk #(
  parameter logic [7:0] MODE_KEY = 8'h43
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cpu_addr,
  input logic [7:0] cpu_wdata,
  input logic       cpu_wr,
  input logic       be_req,
  input logic       be_ack,
  input logic       be_fail,
  input logic       busy,
  input logic       ready,
  input logic       failed,
  input logic       in_mode
);
  logic known;
  assign known = (cpu_wdata == 8'h80) || (cpu_wdata == 8'hA0) ||
                 (cpu_wdata == 8'hC0) || (cpu_wdata == 8'hE0);

  assert_ready_has_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> busy);

  assert_abort_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 4'd0 && cpu_wdata != MODE_KEY) |=> (!busy && !be_req));

  assert_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && !busy && cpu_wr && cpu_addr == 4'd8 && !known) |=> (failed && !busy && !be_req));

  assert_fail_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && be_ack && be_fail && !(cpu_wr && cpu_addr == 4'd0)) |=> (failed && !busy && !ready));

  assert_req_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |-> (busy && !ready));

  assert_busy_cmd_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !failed && cpu_wr && cpu_addr == 4'd8 && !(be_ack && be_fail)) |=> !failed);
endmodule

bind sector_cmd_regif sector_cmd_regif_chk #(.MODE_KEY(MODE_KEY)) u_chk (.*);

// File: tb/tb_sector_cmd_regif.sv
module tb_sector_cmd_regif;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'h0, 8'h43, 8'h00},
    {1'b1, 4'h9, 8'h12, 8'h00},
    {1'b1, 4'hA, 8'h34, 8'h00},
    {1'b1, 4'hB, 8'h56, 8'h00},
    {1'b0, 4'h9, 8'h00, 8'h12},
    {1'b0, 4'hA, 8'h00, 8'h34},
    {1'b0, 4'hB, 8'h00, 8'h56},
    {1'b0, 4'h8, 8'h00, 8'h00},
    {1'b0, 4'h5, 8'h00, 8'hFF},
    {1'b0, 4'h0, 8'h00, 8'hFF},
    {1'b0, 4'hF, 8'h00, 8'hFF},
    {1'b1, 4'h0, 8'h00, 8'h00},
    {1'b0, 4'h9, 8'h00, 8'hFF},
    {1'b1, 4'h9, 8'h99, 8'h00},
    {1'b1, 4'h0, 8'h43, 8'h00},
    {1'b0, 4'h9, 8'h00, 8'h12}
  };

  logic clk = 0, rst_n = 0;
  logic [3:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic cpu_wr = 0, cpu_rd = 0;
  logic be_req, be_write, be_we, be_ack, be_fail;
  logic [7:0] be_cmd, be_rdata, be_wdata, be_addr;
  logic [23:0] be_lba;

  sector_cmd_regif dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int stub_delay = 2, s_reqs = 0;
  logic stub_fail = 0, s_wr = 0;
  logic [23:0] s_lba = 0;
  logic [7:0] smem [256];

  function automatic logic [7:0] pat(input int i, input logic [23:0] l);
    return 8'(i) ^ l[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1;
    #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic wait_status(input logic [7:0] want, output logic [7:0] last, output logic saw_ready);
    saw_ready = 0;
    for (int k = 0; k < 3000; k++) begin
      bus_rd(4'h8, last);
      if (last[1]) saw_ready = 1;
      if (last == want) break;
    end
  endtask

  initial begin
    be_ack = 0; be_fail = 0; be_we = 0; be_addr = 0; be_wdata = 0;
    forever begin
      @(negedge clk);
      if (be_req) begin
        s_reqs++; s_lba = be_lba; s_wr = be_write;
        if (be_write) begin
          for (int i = 0; i < 256; i++) begin
            be_addr = 8'(i); #1 smem[i] = be_rdata; @(negedge clk);
          end
        end else if (be_cmd == 8'h80) begin
          for (int i = 0; i < 256; i++) begin
            be_we = 1; be_addr = 8'(i); be_wdata = pat(i, be_lba); @(negedge clk);
          end
          be_we = 0;
        end
        repeat (stub_delay) @(negedge clk);
        if (be_req) begin
          be_ack = 1; be_fail = stub_fail;
          @(negedge clk);
          be_ack = 0; be_fail = 0;
        end
      end
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] d, st;
    logic sr;
    int bad, reqs0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, window closed
    bus_rd(4'h8, d); chk("R1 reset status closed", d, 8'hFF);
    chk("R1 reset no request", be_req, 0);

    // R1 R4 R10 register table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][20]) bus_wr(VEC[v][19:16], VEC[v][15:8]);
      else begin
        bus_rd(VEC[v][19:16], d);
        chk($sformatf("R1/R4/R10 vector %0d", v), d, VEC[v][7:0]);
      end
    end

    // R5 R4 sector read
    bus_wr(4'h8, 8'h80);
    wait_status(8'h03, st, sr);
    chk("R5 ready after fill", st, 8'h03);
    chk("R4 lba presented", s_lba, 24'h123456);
    chk("R5 request direction", s_wr, 0);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      bus_rd((i % 2) ? 4'hB : 4'hA, d);
      if (d != pat(i, 24'h123456)) bad++;
      if (i == 129) begin
        bus_rd(4'h8, st); chk("R3 status mid transfer", st, 8'h03);
      end
    end
    chk("R5 R3 read data mismatches", bad, 0);
    bus_rd(4'h8, st); chk("R5 done after last byte", st, 8'h00);

    // R6 sector write
    bus_wr(4'h8, 8'hA0);
    bus_rd(4'h8, st); chk("R6 ready before data", st, 8'h03);
    for (int i = 0; i < 256; i++) bus_wr((i % 2) ? 4'hB : 4'hA, 8'(i) ^ 8'hC3);
    bus_rd(4'h8, st); chk("R6 busy after last byte", st, 8'h01);
    wait_status(8'h00, st, sr);
    chk("R6 complete", st, 8'h00);
    chk("R6 request direction", s_wr, 1);
    bad = 0;
    for (int i = 0; i < 256; i++) if (smem[i] != (8'(i) ^ 8'hC3)) bad++;
    chk("R6 written block mismatches", bad, 0);

    // R8 unknown code
    reqs0 = s_reqs;
    bus_wr(4'h8, 8'h55);
    bus_rd(4'h8, st); chk("R8 failed set", st, 8'h80);
    repeat (5) @(negedge clk);
    chk("R8 no request", s_reqs, reqs0);

    // R7 extended, no block; also clears failed (R8)
    stub_delay = 5;
    bus_wr(4'h8, 8'hC0);
    bus_rd(4'h8, st); chk("R7 busy only", st, 8'h01);
    wait_status(8'h00, st, sr);
    chk("R7 R8 complete failed cleared", st, 8'h00);
    chk("R7 ready never set", sr, 0);

    // R9 failing acknowledge
    stub_fail = 1;
    bus_wr(4'h8, 8'hC0);
    wait_status(8'h80, st, sr);
    chk("R9 failed completion", st, 8'h80);
    stub_fail = 0;

    // R11 command while busy
    bus_wr(4'h8, 8'hA0);
    bus_wr(4'h8, 8'h55);
    bus_rd(4'h8, st); chk("R11 busy command ignored", st, 8'h03);

    // R2 abort during push
    bus_wr(4'h0, 8'h00);
    bus_rd(4'h8, st); chk("R2 closed reads FF", st, 8'hFF);
    bus_wr(4'h0, 8'h43);
    bus_rd(4'h8, st); chk("R2 push aborted", st, 8'h00);

    // R2 abort during execution
    stub_delay = 40;
    reqs0 = s_reqs;
    bus_wr(4'h8, 8'hC0);
    repeat (4) @(negedge clk);
    chk("R2 request open", be_req, 1);
    bus_wr(4'h0, 8'h00);
    chk("R2 request dropped", be_req, 0);
    bus_wr(4'h0, 8'h43);
    bus_rd(4'h8, st); chk("R2 exec aborted", st, 8'h00);
    repeat (60) @(negedge clk);
    bus_rd(4'h8, st); chk("R2 no late completion", st, 8'h00);

    report();
  end
endmodule